// File: doc/BRIEF.md
# MDIO Management Master

This block runs PHY register reads and writes over the two-wire management bus on behalf of the rest of the chip. A requester presents a one-cycle request with the operation, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the complete serial frame on a divided management clock. The frame is the preamble, start and opcode fields, both addresses, the turnaround and the data. The block reports completion with a single-cycle done pulse that carries the read data and an error flag.

The bidirectional data pin is split into a data output, a data input and an output enable. The output enable is high while the host drives the line and low while the PHY drives it. Every change of data or direction happens in the low half of the management clock, so a PHY that samples on the rising edge always sees settled values. A read addressed to a PHY that does not answer sees the line still pulled high in the second turnaround slot. It is reported with the error flag set and the data forced to zero.

The management clock is the system clock divided by `2*HALF_DIV`. `HALF_DIV` must be at least 2 and should be chosen so that the management clock stays at or below 2.5 MHz. The default of 20 suits a 100 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc_o is 0, mdoe_o is 1, mdo_o is 1, and busy_o and done_o are 0.
- R2: While a transaction runs, every high phase and every low phase of mdc_o lasts exactly HALF_DIV system clocks. Whenever busy_o is 0, mdc_o is 0.
- R3: Each frame begins with 32 management clock periods in which the host drives mdo_o high.
- R4: After the preamble, the host sends these fields, each MSB first: start code 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, then the 5-bit register address.
- R5: A write continues with turnaround code 10 and then the 16 data bits MSB first. mdoe_o stays 1 for all 64 clock periods of a write.
- R6: A read keeps mdoe_o at 1 for exactly the first 46 clock periods. mdoe_o then falls while mdc_o is low, and mdoe_o never changes in a system clock in which mdc_o is high or has just been high.
- R7: During a read, mdi_i is sampled at the end of the low phase of clock period 47, counting from 0. If it is 1, err_o is 1 and rdata_o is 0 at done_o, regardless of the later data bits. A write always ends with err_o at 0.
- R8: The 16 read data bits are sampled at the end of the low phases of clock periods 48 to 63 and are returned MSB first in rdata_o.
- R9: After the last clock period, the host drives the line again (mdoe_o back to 1) with mdc_o low. Only after that does done_o pulse. mdoe_o is 1 whenever busy_o is 0.
- R10: While mdoe_o is 1, mdo_o changes only when mdc_o is low and was low in the previous system clock.
- R11: A request is taken when req_valid_i is 1 and busy_o is 0. busy_o then stays 1 until the cycle of a one-cycle done_o pulse, in which it falls. Requests presented while busy_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when busy_o is 0 |
| req_read_i | input | 1 | 1 = register read, 0 = register write |
| req_phy_i | input | 5 | PHY address |
| req_reg_i | input | 5 | Register address |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid with done_o |
| err_o | output | 1 | No PHY answered the read, valid with done_o |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data toward the PHY |
| mdoe_o | output | 1 | 1 = host drives the data line |
| mdi_i | input | 1 | Serial data from the line |

## Verification
A behavioural PHY on the pins answers reads only at one address and keeps the line pulled high otherwise. Reads to the missing address therefore see all ones. A design that skipped the error test or failed to mask the data would return 0xFFFF instead of zero with the error flag. The PHY drives each bit just after the falling edge. A sampler shifted by one slot, or one that sampled after the rising edge, would return data rotated by one position, and a misplaced error slot would read a data bit as the error. Direction and data are recorded at every rising and falling edge to catch a release or a restore that coincides with a clock edge. A request pulsed in the middle of a write must leave no trace in the frame, in the stored register value or in the done count.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] ST_CODE = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  // start + opcode + two addresses
  localparam int HDR_W  = 4 + 2 * ADDR_W;
  // turnaround + data
  localparam int BODY_W = 2 + DATA_W;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH, PH_TAIL} phase_e;
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = run_i && (cnt_q == '0);
  assign last_o  = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = PRE_LEN + HDR_W + BODY_W,
  parameter int BIT_W   = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               rd_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_first_i,
  input  logic               tick_last_i,
  output logic               run_o,
  output logic               mdc_o,
  output logic               mdo_o,
  output logic               mdoe_o,
  output logic               busy_o,
  output logic [BIT_W-1:0]   bit_idx_o,
  output logic               sample_o,
  output logic               finish_o
);
  localparam logic [BIT_W-1:0] REL_IDX  = BIT_W'(PRE_LEN + HDR_W);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_W - 1);

  phase_e             phase_q;
  logic [FRAME_W-1:0] shift_q;
  logic [BIT_W-1:0]   bit_q;
  logic               rd_q;
  logic               drive_nxt;

  // host releases the line from the first turnaround slot of a read
  assign drive_nxt = !(rd_q && (bit_q >= REL_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      shift_q <= '0;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      mdc_o   <= 1'b0;
      mdo_o   <= 1'b1;
      mdoe_o  <= 1'b1;
      busy_o  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_LOW;
            shift_q <= frame_i;
            bit_q   <= '0;
            rd_q    <= rd_i;
            busy_o  <= 1'b1;
          end
        end
        PH_LOW: begin
          // one clock after the falling edge: safe to move data/direction
          if (tick_first_i) begin
            mdoe_o <= drive_nxt;
            mdo_o  <= drive_nxt ? shift_q[FRAME_W-1] : 1'b1;
          end
          if (tick_last_i) begin
            mdc_o   <= 1'b1;
            phase_q <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tick_last_i) begin
            mdc_o   <= 1'b0;
            shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
            if (bit_q == LAST_IDX) begin
              phase_q <= PH_TAIL;
            end else begin
              bit_q   <= bit_q + 1'b1;
              phase_q <= PH_LOW;
            end
          end
        end
        PH_TAIL: begin
          if (tick_first_i) begin
            mdoe_o <= 1'b1;
            mdo_o  <= 1'b1;
          end
          if (tick_last_i) begin
            phase_q <= PH_IDLE;
            busy_o  <= 1'b0;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign run_o     = (phase_q != PH_IDLE);
  assign bit_idx_o = bit_q;
  assign sample_o  = (phase_q == PH_LOW) && tick_last_i && rd_q;
  assign finish_o  = (phase_q == PH_TAIL) && tick_last_i;
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
#(
  parameter int REL_POS = 46,
  parameter int BIT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic              mdi_i,
  input  logic              finish_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              done_o
);
  // second turnaround slot carries the presence check
  localparam logic [BIT_W-1:0] ERR_IDX = BIT_W'(REL_POS + 1);
  localparam logic [BIT_W-1:0] DAT_IDX = BIT_W'(REL_POS + 2);

  logic              err_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      dat_q <= '0;
    end else if (clear_i) begin
      err_q <= 1'b0;
      dat_q <= '0;
    end else if (sample_i) begin
      if (bit_idx_i == ERR_IDX)      err_q <= mdi_i;
      else if (bit_idx_i >= DAT_IDX) dat_q <= {dat_q[DATA_W-2:0], mdi_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        rdata_o <= err_q ? '0 : dat_q;
        err_o   <= err_q;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_read_i,
  input  logic [ADDR_W-1:0] req_phy_i,
  input  logic [ADDR_W-1:0] req_reg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdo_o,
  output logic              mdoe_o,
  input  logic              mdi_i
);
  localparam int FRAME_W = PRE_LEN + HDR_W + BODY_W;
  localparam int BIT_W   = $clog2(FRAME_W);

  logic               start;
  logic               run;
  logic               t_first, t_last;
  logic               sample, finish;
  logic [BIT_W-1:0]   bit_idx;
  logic [FRAME_W-1:0] frame;

  assign start = req_valid_i && !busy_o;

  always_comb begin
    if (req_read_i)
      frame = {{PRE_LEN{1'b1}}, ST_CODE, OP_RD, req_phy_i, req_reg_i, {BODY_W{1'b1}}};
    else
      frame = {{PRE_LEN{1'b1}}, ST_CODE, OP_WR, req_phy_i, req_reg_i, TA_WR, req_wdata_i};
  end

  mdio_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .first_o (t_first),
    .last_o  (t_last)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .BIT_W(BIT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .rd_i         (req_read_i),
    .frame_i      (frame),
    .tick_first_i (t_first),
    .tick_last_i  (t_last),
    .run_o        (run),
    .mdc_o        (mdc_o),
    .mdo_o        (mdo_o),
    .mdoe_o       (mdoe_o),
    .busy_o       (busy_o),
    .bit_idx_o    (bit_idx),
    .sample_o     (sample),
    .finish_o     (finish)
  );

  mdio_rx_capture #(.REL_POS(PRE_LEN + HDR_W), .BIT_W(BIT_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .sample_i  (sample),
    .bit_idx_i (bit_idx),
    .mdi_i     (mdi_i),
    .finish_i  (finish),
    .rdata_o   (rdata_o),
    .err_o     (err_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] rdata_o,
  input logic        err_o,
  input logic        mdc_o,
  input logic        mdo_o,
  input logic        mdoe_o
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o); // R2
  AST_OE_ONLY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o || $past(mdc_o)) |-> $stable(mdoe_o)); // R6
  AST_ERR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rdata_o == 16'h0)); // R7
  AST_IDLE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> mdoe_o); // R9
  AST_MDO_ONLY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mdc_o || $past(mdc_o)) && mdoe_o && $past(mdoe_o)) |-> $stable(mdo_o)); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R11
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .mdc_o   (mdc_o),
  .mdo_o   (mdo_o),
  .mdoe_o  (mdoe_o)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam logic [4:0] PHY_HERE = 5'd3;
  localparam logic [4:0] PHY_GONE = 5'd7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_read_i = 1'b0;
  logic [4:0]  req_phy_i = '0;
  logic [4:0]  req_reg_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        busy_o, done_o, err_o, mdc_o, mdo_o, mdoe_o;
  logic [15:0] rdata_o;
  logic        mdi_i = 1'b1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mdio_master #(.HALF_DIV(HALF)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_read_i(req_read_i),
    .req_phy_i(req_phy_i), .req_reg_i(req_reg_i), .req_wdata_i(req_wdata_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .err_o(err_o),
    .mdc_o(mdc_o), .mdo_o(mdo_o), .mdoe_o(mdoe_o), .mdi_i(mdi_i)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int i);
    logic [3:0] k = 4'(i);
    return {k, ~k, k ^ 4'h9, 4'h6};
  endfunction

  // ---------------- behavioural PHY on the pins ----------------
  logic [15:0] phy_mem [32];
  logic [63:0] cap;
  int          cap_n, rise_k;
  logic        oe_rise, mdo_rise;
  logic        cur_rd, cur_hit;
  logic [4:0]  cur_reg;
  int          dir_viol, per_viol;
  int          cyc, t_rise, t_fall;

  initial for (int i = 0; i < 32; i++) phy_mem[i] = init_val(i);

  always @(negedge clk_i) cyc++;

  always @(posedge mdc_o) begin
    if (mdoe_o) begin
      cap[63 - cap_n] = mdo_o;
      cap_n++;
    end
    oe_rise  = mdoe_o;
    mdo_rise = mdo_o;
    if (rise_k > 0 && (cyc - t_fall) != HALF) per_viol++;
    t_rise = cyc;
    if (rise_k == 45) begin
      cur_rd  = (cap[29:28] == 2'b10);
      cur_hit = (cap[27:23] == PHY_HERE);
      cur_reg = cap[22:18];
    end
    if (rise_k == 63 && !cur_rd && cur_hit) phy_mem[cur_reg] = cap[15:0];
    rise_k++;
  end

  always @(negedge mdc_o) begin
    if (mdoe_o != oe_rise || (mdoe_o && mdo_o != mdo_rise)) dir_viol++;
    if ((cyc - t_rise) != HALF) per_viol++;
    t_fall = cyc;
    if (cur_rd && rise_k == 47)
      mdi_i = !cur_hit;
    else if (cur_rd && rise_k >= 48 && rise_k <= 63)
      mdi_i = cur_hit ? phy_mem[cur_reg][63 - rise_k] : 1'b1;
    else
      mdi_i = 1'b1;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          rd;
    logic [63:0] frame;
    logic [15:0] rdata;
    bit          err;
  } item_t;

  item_t       sb_q[$];
  logic [15:0] shadow [32];
  int          n_done;

  initial for (int i = 0; i < 32; i++) shadow[i] = init_val(i);

  task automatic clr_cap();
    cap = '0; cap_n = 0; rise_k = 0; cur_rd = 0; cur_hit = 0; cur_reg = '0;
    dir_viol = 0; per_viol = 0;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      item_t it;
      n_done++;
      if (sb_q.size() == 0) begin
        chk(0, "R11 unexpected done", 1, 0);
      end else begin
        it = sb_q.pop_front();
        chk(cap[63:32] == 32'hFFFF_FFFF, "R3 preamble", cap[63:32], 32'hFFFF_FFFF);
        chk(cap[31:18] == it.frame[31:18], "R4 header", cap[31:18], it.frame[31:18]);
        chk(rise_k == 64, "R2 clock count", rise_k, 64);
        chk(per_viol == 0, "R2 half periods", per_viol, 0);
        chk(dir_viol == 0, "R10 R6 change while high", dir_viol, 0);
        chk(mdoe_o && !mdc_o, "R9 driven at end", {mdoe_o, mdc_o}, 2'b10);
        if (it.rd) begin
          chk(cap_n == 46, "R6 driven slots", cap_n, 46);
          chk(err_o == it.err, "R7 err flag", err_o, it.err);
          chk(rdata_o == it.rdata, "R8 R7 read data", rdata_o, it.rdata);
        end else begin
          chk(cap_n == 64, "R5 driven slots", cap_n, 64);
          chk(cap[17:0] == it.frame[17:0], "R5 ta+data", cap[17:0], it.frame[17:0]);
          chk(err_o == 1'b0, "R7 write err", err_o, 0);
        end
      end
      clr_cap();
    end
  end

  task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    item_t it;
    it.rd = rd;
    if (rd) begin
      it.frame = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 18'h0};
      it.err   = (phy != PHY_HERE);
      it.rdata = it.err ? 16'h0 : shadow[rg];
    end else begin
      it.frame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, wd};
      it.err   = 1'b0;
      it.rdata = 16'h0;
      if (phy == PHY_HERE) shadow[rg] = wd;
    end
    sb_q.push_back(it);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_read_i = rd; req_phy_i = phy; req_reg_i = rg; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o, "R11 busy after accept", busy_o, 1);
  endtask

  task automatic txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    issue(rd, phy, rg, wd);
    while (sb_q.size() != 0) @(negedge clk_i);
    chk(!done_o, "R11 done one cycle", done_o, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    n_done = 0;
    clr_cap();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!mdc_o && mdoe_o && mdo_o && !busy_o && !done_o, "R1 reset outputs",
        {mdc_o, mdoe_o, mdo_o, busy_o, done_o}, 5'b01100);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!mdc_o && !busy_o, "R2 idle clock low", {mdc_o, busy_o}, 0);

    txn(0, PHY_HERE, 5'd5, 16'h8001);
    txn(1, PHY_HERE, 5'd5, 16'h0);
    txn(1, PHY_HERE, 5'd31, 16'h0);
    txn(0, PHY_HERE, 5'd0, 16'hFFFF);
    txn(1, PHY_HERE, 5'd0, 16'h0);
    txn(1, PHY_GONE, 5'd9, 16'h0);
    txn(0, PHY_GONE, 5'd9, 16'h1357);
    txn(0, PHY_HERE, 5'd31, 16'h5A3C);
    txn(1, PHY_HERE, 5'd31, 16'h0);
    txn(1, PHY_HERE, 5'd10, 16'h0);

    // R11 request while busy is ignored
    issue(0, PHY_HERE, 5'd2, 16'h1234);
    repeat (20) @(negedge clk_i);
    req_valid_i = 1'b1; req_read_i = 1'b1; req_phy_i = PHY_GONE; req_reg_i = 5'd2;
    repeat (3) @(negedge clk_i);
    req_valid_i = 1'b0;
    while (sb_q.size() != 0) @(negedge clk_i);
    repeat (2 * HALF * 4) @(negedge clk_i);
    chk(!busy_o, "R11 ignored request not started", busy_o, 0);
    chk(n_done == 11, "R11 done count", n_done, 11);
    txn(1, PHY_HERE, 5'd2, 16'h0);

    repeat (5) @(negedge clk_i);
    finish_run();
  end
endmodule